// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit floating-point numbers held as a sign bit, an 8-bit biased exponent and a 23-bit fraction with a hidden leading one. An operand pair enters through a valid/ready handshake. One cycle after it is accepted, a registered product appears on a second valid/ready handshake. The product carries the XOR of the operand signs. Its exponent is the sum of the two exponents less the bias. Its significand is the 48-bit product of the two 24-bit significands. Because that product always lies in [1,4), a single conditional right shift by one bit, paired with an exponent increment, normalizes it. The fraction is then cut to 23 bits with no rounding.

A biased exponent that leaves the representable range is flagged. When it is too large, the output is an infinity and an overflow flag is raised. When it is too small, the output is a zero and an underflow flag is raised. In both cases the output keeps the sign of the product. Any operand with a zero exponent field, which includes subnormals, counts as zero and yields a signed zero with no flags. Rounding, NaN and infinity semantics and division are not part of the block.

Top module: `fp_mult_core`

## Requirements
- R1: The result sign bit (bit 31) equals the XOR of the operand sign bits in every case, including zero, overflow and underflow results.
- R2: When the significand product lies in [1,2), the result exponent field (bits 30:23) is eA+eB-127. The fraction field (bits 22:0) is the 23 product bits just below the leading one.
- R3: When the significand product lies in [2,4), the product is shifted right by one and the exponent is one greater than eA+eB-127.
- R4: The fraction is truncated. Product bits below the kept 23 are discarded even when they are all ones, and never round the result up.
- R5: When the final biased exponent is 255 or more, the result is an infinity (exponent field all ones, fraction zero) with the product sign, and ovfFlag is 1 while unfFlag is 0.
- R6: When the final biased exponent is 0 or less, the result is a zero with the product sign, and unfFlag is 1 while ovfFlag is 0.
- R7: When either operand has an exponent field of 0, the result is a zero with the product sign and both flags are 0, whatever the other operand holds.
- R8: inReady is high when outValid is low or outReady is high. After an accepted input (inValid and inReady at a clock edge), outValid is high in the following cycle and carries that input's product.
- R9: While outValid is high and outReady is low, result, ovfFlag, unfFlag and outValid hold their values and inReady is low.
- R10: After reset, outValid is low, result is zero and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand pair present |
| inReady | output | 1 | Block can accept an operand pair |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| outValid | output | 1 | Product present |
| outReady | input | 1 | Consumer takes the product |
| result | output | 32 | Product word |
| ovfFlag | output | 1 | Exponent overflow on this product |
| unfFlag | output | 1 | Exponent underflow on this product |

## Verification
The bench uses two sets of directed significand pairs. Pairs such as 1.25 x 1.25 keep the product below two, and pairs such as 1.5 x 1.5 push it above two, so a wrong shift choice or a missing exponent increment shows up. An operand pair whose low product bits are all ones tells truncation apart from rounding. Exponent pairs that land exactly on 254, 255, 1 and 0 probe both range edges. Zero and subnormal operands, including one paired with the largest exponent, confirm that the zero path overrides overflow. A long run of random operands under random backpressure then covers the handshake ordering and the holding of the output.

// File: rtl/fp_mult_pkg.sv
package fp_mult_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic capture;
  } fpmStrobes_t;
endpackage

// File: rtl/fp_mult_ctrl.sv
module fp_mult_ctrl
  import fp_mult_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic        outReady,
  output logic        outValid,
  output fpmStrobes_t strobes
);
  logic validReg;
  logic accept;

  assign inReady = !validReg || outReady;
  assign accept  = inValid && inReady;
  assign strobes.capture = accept;
  assign outValid = validReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              validReg <= 1'b0;
    else if (accept)        validReg <= 1'b1;
    else if (outReady)      validReg <= 1'b0;
  end

  // R8
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R9
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);
endmodule

// File: rtl/fp_mult_datapath.sv
module fp_mult_datapath
  import fp_mult_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fpmStrobes_t          strobes,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                 ovfFlag,
  output logic                 unfFlag
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int EXT_W  = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX   = (1 << EXP_W) - 1;
  localparam logic signed [EXT_W-1:0] EXT_EMAX = EXT_W'(EMAX);
  localparam logic signed [EXT_W-1:0] EXT_ZERO = '0;

  logic                 signOut;
  logic [EXP_W-1:0]     expA, expB;
  logic                 zeroIn;
  logic [PROD_W-1:0]    sigA, sigB, prod;
  logic                 hiRange;
  logic [FRAC_W-1:0]    normFrac;
  logic [EXT_W-1:0]     sumU;
  logic signed [EXT_W-1:0] expSum;
  logic                 ovfNext, unfNext;
  logic [WORD_W-1:0]    resNext;

  always_comb begin
    signOut = opA[WORD_W-1] ^ opB[WORD_W-1];
    expA    = opA[WORD_W-2 -: EXP_W];
    expB    = opB[WORD_W-2 -: EXP_W];
    zeroIn  = (expA == '0) || (expB == '0);
    sigA    = PROD_W'({1'b1, opA[FRAC_W-1:0]});
    sigB    = PROD_W'({1'b1, opB[FRAC_W-1:0]});
    prod    = sigA * sigB;
    hiRange = prod[PROD_W-1];
    normFrac = hiRange ? prod[PROD_W-2 -: FRAC_W] : prod[PROD_W-3 -: FRAC_W];
    sumU    = EXT_W'(expA) + EXT_W'(expB) + EXT_W'(hiRange) - EXT_W'(BIAS);
    expSum  = $signed(sumU);
    ovfNext = !zeroIn && (expSum >= EXT_EMAX);
    unfNext = !zeroIn && (expSum <= EXT_ZERO);
    if (zeroIn || unfNext)
      resNext = {signOut, {(WORD_W-1){1'b0}}};
    else if (ovfNext)
      resNext = {signOut, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      resNext = {signOut, expSum[EXP_W-1:0], normFrac};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result  <= '0;
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else if (strobes.capture) begin
      result  <= resNext;
      ovfFlag <= ovfNext;
      unfFlag <= unfNext;
    end
  end

  // R1
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> result[WORD_W-1] == $past(opA[WORD_W-1] ^ opB[WORD_W-1]));

  // R5
  ovf_inf_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |-> (result[WORD_W-2 -: EXP_W] == {EXP_W{1'b1}}) && (result[FRAC_W-1:0] == '0) && !unfFlag);

  // R6
  unf_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    unfFlag |-> (result[WORD_W-2:0] == '0) && !ovfFlag);

  // R7
  zero_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && ((opA[WORD_W-2 -: EXP_W] == '0) || (opB[WORD_W-2 -: EXP_W] == '0)))
      |=> (result[WORD_W-2:0] == '0) && !ovfFlag && !unfFlag);
endmodule

// File: rtl/fp_mult_core.sv
module fp_mult_core
  import fp_mult_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [EXP_W+FRAC_W:0]  opA,
  input  logic [EXP_W+FRAC_W:0]  opB,
  output logic                   outValid,
  input  logic                   outReady,
  output logic [EXP_W+FRAC_W:0]  result,
  output logic                   ovfFlag,
  output logic                   unfFlag
);
  fpmStrobes_t strobes;

  fp_mult_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outReady(outReady), .outValid(outValid), .strobes(strobes)
  );

  fp_mult_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opA(opA), .opB(opB),
    .result(result), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(result) && $stable(ovfFlag) && $stable(unfFlag));

  // R9
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);
endmodule

// File: tb/fp_mult_core_test.sv
module fp_mult_core_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [31:0] opA = '0, opB = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [31:0] result;
  logic ovfFlag, unfFlag;

  int checks = 0;
  int fails = 0;
  bit randReady = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic ovf;
    logic unf;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  fp_mult_core uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opA(opA), .opB(opB), .outValid(outValid), .outReady(outReady),
    .result(result), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic expItem_t model(input logic [31:0] a, input logic [31:0] b, input string tag);
    expItem_t it;
    logic s;
    int ea, eb, e;
    logic [47:0] p;
    logic [22:0] f;
    s = a[31] ^ b[31];
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    it.tag = tag;
    it.ovf = 1'b0;
    it.unf = 1'b0;
    if (ea == 0 || eb == 0) begin
      it.res = {s, 31'd0};
      return it;
    end
    p = 48'({1'b1, a[22:0]}) * 48'({1'b1, b[22:0]});
    e = ea + eb - 127;
    if (p[47]) begin
      e = e + 1;
      f = p[46:24];
    end else begin
      f = p[45:23];
    end
    if (e >= 255) begin
      it.ovf = 1'b1;
      it.res = {s, 8'hFF, 23'd0};
    end else if (e <= 0) begin
      it.unf = 1'b1;
      it.res = {s, 31'd0};
    end else begin
      it.res = {s, e[7:0], f};
    end
    return it;
  endfunction

  task automatic send(input logic [31:0] a, input logic [31:0] b, input string tag);
    expQ.push_back(model(a, b, tag));
    @(negedge clk);
    opA = a; opB = b; inValid = 1'b1;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    #1;
    // R8: product valid in the cycle after acceptance
    check(outValid === 1'b1, "R8 valid after accept", 64'(outValid), 64'd1);
  endtask

  // consumer ready driver
  always @(negedge clk) begin
    if (randReady) outReady <= ($urandom % 3) != 0;
    else           outReady <= 1'b1;
  end

  // monitor / scoreboard
  logic heldPrev = 1'b0;
  logic [33:0] heldVal = '0;
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (heldPrev) begin
        // R9: stalled output holds
        check(outValid === 1'b1 && {result, ovfFlag, unfFlag} === heldVal, "R9 hold",
              64'({outValid, result, ovfFlag, unfFlag}), 64'({1'b1, heldVal}));
      end
      if (outValid && !outReady) begin
        check(inReady === 1'b0, "R9 stall inReady", 64'(inReady), 64'd0);
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected output", 64'(result), 64'd0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check({result, ovfFlag, unfFlag} === {it.res, it.ovf, it.unf}, it.tag,
                64'({result, ovfFlag, unfFlag}), 64'({it.res, it.ovf, it.unf}));
        end
      end
      heldPrev = outValid && !outReady;
      heldVal  = {result, ovfFlag, unfFlag};
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        #1;
        // R10: reset state
        check(outValid === 1'b0 && result === 32'd0 && ovfFlag === 1'b0 && unfFlag === 1'b0,
              "R10 reset", 64'({outValid, result, ovfFlag, unfFlag}), 64'd0);
        @(negedge clk);
        rstN = 1'b1;
        #1;
        check(inReady === 1'b1 && outValid === 1'b0, "R10 idle after reset",
              64'({inReady, outValid}), 64'b10);

        send(32'h3FA00000, 32'h3FA00000, "R2 1.25*1.25");
        send(32'h3FC00000, 32'h3FC00000, "R3 1.5*1.5");
        send(32'hC0000000, 32'h40400000, "R1 -2*3");
        send(32'hBFC00000, 32'hBFC00000, "R1 neg*neg");
        send(32'h3F800001, 32'h3FFFFFFF, "R4 truncation high");
        send(32'h3FFFFFFF, 32'h3FFFFFFF, "R4 truncation all ones");
        send(32'h7F000000, 32'h7F000000, "R5 overflow");
        send(32'hFF000000, 32'h7F000000, "R5 negative overflow");
        send(32'h5F800000, 32'h5F800000, "R5 exponent exactly 255");
        send(32'h5F800000, 32'h5F000000, "R2 exponent 254");
        send(32'h00800000, 32'h00800000, "R6 underflow");
        send(32'h80800000, 32'h00800000, "R6 negative underflow");
        send(32'h1F800000, 32'h20000000, "R6 exponent exactly 0");
        send(32'h20000000, 32'h20000000, "R2 exponent 1");
        send(32'h1FFFFFFF, 32'h1FFFFFFF, "R3 shift lifts exponent to 0 edge");
        send(32'h00000000, 32'h7F000000, "R7 zero times large");
        send(32'h80000000, 32'h3F800000, "R7 negative zero");
        send(32'h00000001, 32'h7F800000, "R7 subnormal vs max exponent");
        send(32'h40000000, 32'h807FFFFF, "R7 subnormal second operand");

        randReady = 1'b1;
        for (int i = 0; i < 400; i++) begin
          send($urandom, $urandom, "R2 random");
        end
        randReady = 1'b0;
        while (expQ.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
      end
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R8 watchdog expired", 64'd0, 64'd1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule